// File: doc/BRIEF.md
# Self-sized signed displacement decoder

This block sits behind an instruction fetch path and turns one variable-length signed displacement into a 32-bit two's-complement value. Bytes arrive one per cycle through a valid/ready byte port. A start flag, sampled with a byte, marks that byte as the opening byte of a displacement. The leading bits of that opening byte alone set the length: one, two or four bytes. The bytes that follow are gathered with the most significant byte first. Once the final byte has been taken, the prefix bits are removed, the remaining payload is sign-extended from its own top bit, and the result is presented for one cycle with its byte count.

The byte port never applies back-pressure: `in_ready` stays high out of reset, both while idle and while collecting, so a byte is taken in every cycle where `in_valid` is high. The upstream fetch logic can pause between bytes by holding `in_valid` low for any number of cycles. If a new start arrives before the current displacement is complete, the partial value is dropped, an error strobe is raised and the new byte opens a fresh displacement.

Top module: `vdisp_decoder`

## Requirements
- R1: `in_ready` is high in every cycle after reset; a byte is taken in each cycle where `in_valid` is high.
- R2: An opening byte with bit 7 equal to 0 is a complete displacement. In the cycle after it is taken, `out_done` is 1, `out_len` is 1 and `out_value` is bits 6..0 sign-extended from bit 6 (range -64..63).
- R3: An opening byte whose bits 7..6 are `10` starts a two-byte displacement. The value is the 14 bits formed by bits 5..0 of the opening byte followed by the whole second byte, sign-extended from its top bit (range -8192..8191). `out_done` rises with `out_len` = 2 in the cycle after the second byte is taken.
- R4: An opening byte whose bits 7..6 are `11` starts a four-byte displacement. The value is the 30 bits formed by bits 5..0 of the opening byte followed by three more bytes, most significant first, sign-extended (range -536870912..536870911). `out_done` rises with `out_len` = 4 in the cycle after the fourth byte is taken.
- R5: `out_done` is high for exactly one cycle per completed displacement and is low while collection is still in progress. Whenever `out_done` is high, `out_len` is 1, 2 or 4.
- R6: While idle, a byte taken with `in_start` low is ignored: it produces no `out_done`, no `out_err`, and it does not affect the next displacement.
- R7: A byte taken with `in_start` high while a displacement is still incomplete drops the partial value, raises `out_err` for the next cycle only, and is decoded as a new opening byte. If that byte is a one-byte displacement, `out_done` rises in the same cycle as `out_err`.
- R8: Cycles with `in_valid` low change nothing, whatever `in_start` and `in_byte` hold, so gaps may appear between the bytes of a displacement.
- R9: Immediately after reset, `out_done` and `out_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_ready | output | 1 | Byte port accepts; high after reset |
| in_byte | input | 8 | Displacement byte, most significant first |
| in_start | input | 1 | Marks the offered byte as the opening byte |
| out_done | output | 1 | One-cycle strobe: value and length are valid |
| out_value | output | 32 | Sign-extended displacement |
| out_len | output | 3 | Bytes consumed: 1, 2 or 4 |
| out_err | output | 1 | One-cycle strobe: incomplete displacement discarded |

## Verification
The assertions assume that `in_start`, `in_valid` and `in_byte` are stable around the rising edge and are 0 or 1 once reset is released. They do not assume that starts follow any ordering, because an early start is legal and has a defined outcome. The stimulus changes inputs only on falling edges and holds `in_valid` low during every pause. During those pauses it also drives `in_start` high and `in_byte` to junk, so the properties see the ignored cycles in their worst form. Every opening byte is paired with the byte count its prefix demands, except in the abort sequences, which deliberately cut a displacement short.

// File: rtl/vdisp_pkg.sv
package vdisp_pkg;
  typedef enum logic [1:0] {
    SZ_ONE  = 2'd0,
    SZ_TWO  = 2'd1,
    SZ_FOUR = 2'd2
  } disp_sz_e;

  function automatic logic [2:0] sz_bytes(disp_sz_e sz);
    case (sz)
      SZ_ONE:  return 3'd1;
      SZ_TWO:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/vdisp_classify.sv
module vdisp_classify
  import vdisp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] lead,
  output disp_sz_e          sz
);
  always_comb begin
    if (!lead[BYTE_W-1])      sz = SZ_ONE;
    else if (!lead[BYTE_W-2]) sz = SZ_TWO;
    else                      sz = SZ_FOUR;
  end
endmodule

// File: rtl/vdisp_sext.sv
module vdisp_sext
  import vdisp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int VAL_W  = 32
) (
  input  logic [4*BYTE_W-1:0] raw,
  input  disp_sz_e            sz,
  output logic [VAL_W-1:0]    val
);
  localparam int P1 = BYTE_W - 1;
  localparam int P2 = 2*BYTE_W - 2;
  localparam int P4 = 4*BYTE_W - 2;

  logic [VAL_W-1:0] v1, v2, v4;

  assign v1 = {{(VAL_W-P1){raw[P1-1]}}, raw[P1-1:0]};
  assign v2 = {{(VAL_W-P2){raw[P2-1]}}, raw[P2-1:0]};
  assign v4 = {{(VAL_W-P4){raw[P4-1]}}, raw[P4-1:0]};

  always_comb begin
    case (sz)
      SZ_ONE:  val = v1;
      SZ_TWO:  val = v2;
      default: val = v4;
    endcase
  end
endmodule

// File: rtl/vdisp_collect.sv
module vdisp_collect
  import vdisp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                start,
  input  logic [BYTE_W-1:0]   din,
  input  disp_sz_e            lead_sz,
  output logic                finish,
  output logic                abort,
  output logic [4*BYTE_W-1:0] raw_next,
  output disp_sz_e            fin_sz
);
  localparam int ACC_W = 4*BYTE_W;

  logic             busy_q;
  logic [1:0]       left_q;
  disp_sz_e         sz_q;
  logic [ACC_W-1:0] acc_q;

  logic first, cont;

  assign first = take && start;
  assign cont  = take && busy_q && !start;
  assign abort = first && busy_q;

  always_comb begin
    raw_next = acc_q;
    fin_sz   = sz_q;
    finish   = 1'b0;
    if (first) begin
      raw_next = {{(ACC_W-BYTE_W){1'b0}}, din};
      fin_sz   = lead_sz;
      finish   = (lead_sz == SZ_ONE);
    end else if (cont) begin
      raw_next = {acc_q[ACC_W-BYTE_W-1:0], din};
      finish   = (left_q == 2'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= 2'd0;
      sz_q   <= SZ_ONE;
      acc_q  <= '0;
    end else if (first || cont) begin
      acc_q <= raw_next;
      if (first) begin
        sz_q   <= lead_sz;
        left_q <= 2'(sz_bytes(lead_sz) - 3'd1);
        busy_q <= (lead_sz != SZ_ONE);
      end else begin
        left_q <= left_q - 2'd1;
        busy_q <= (left_q != 2'd1);
      end
    end
  end

  // R5: collection in progress always has bytes still owed
  a_r5_owed_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != 2'd0));
  // R8: state holds when no byte is taken
  a_r8_hold_idle_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(acc_q) && $stable(left_q));
endmodule

// File: rtl/vdisp_decoder.sv
module vdisp_decoder
  import vdisp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int VAL_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_start,
  output logic              out_done,
  output logic [VAL_W-1:0]  out_value,
  output logic [2:0]        out_len,
  output logic              out_err
);
  localparam int ACC_W = 4*BYTE_W;

  logic             take, finish, abort;
  logic [ACC_W-1:0] raw_next;
  disp_sz_e         lead_sz, fin_sz;
  logic [VAL_W-1:0] val_next;
  logic             rdy_q;

  assign in_ready = rdy_q;
  assign take     = in_valid && rdy_q;

  vdisp_classify #(.BYTE_W(BYTE_W)) u_class (
    .lead (in_byte),
    .sz   (lead_sz)
  );

  vdisp_collect #(.BYTE_W(BYTE_W)) u_coll (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .start    (in_start),
    .din      (in_byte),
    .lead_sz  (lead_sz),
    .finish   (finish),
    .abort    (abort),
    .raw_next (raw_next),
    .fin_sz   (fin_sz)
  );

  vdisp_sext #(.BYTE_W(BYTE_W), .VAL_W(VAL_W)) u_sext (
    .raw (raw_next),
    .sz  (fin_sz),
    .val (val_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      out_done  <= 1'b0;
      out_err   <= 1'b0;
      out_value <= '0;
      out_len   <= 3'd0;
    end else begin
      rdy_q    <= 1'b1;
      out_done <= finish;
      out_err  <= abort;
      if (finish) begin
        out_value <= val_next;
        out_len   <= sz_bytes(fin_sz);
      end
    end
  end

  // R1: the byte port never back-pressures after the first cycle out of reset
  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
  // R5: a completed displacement reports a legal byte count
  a_r5_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_len == 3'd1 || out_len == 3'd2 || out_len == 3'd4));
  // R2: one-byte results stay within 7-bit signed range
  a_r2_short_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_len == 3'd1) |->
      (out_value[VAL_W-1:6] == '0 || out_value[VAL_W-1:6] == '1));
  // R3: two-byte results stay within 14-bit signed range
  a_r3_mid_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_len == 3'd2) |->
      (out_value[VAL_W-1:13] == '0 || out_value[VAL_W-1:13] == '1));
  // R4: four-byte results stay within 30-bit signed range
  a_r4_long_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_len == 3'd4) |->
      (out_value[VAL_W-1:29] == '0 || out_value[VAL_W-1:29] == '1));
  // R7: an abort strobe only follows a taken start byte
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> $past(in_valid && in_start));
  // R8: a completion only follows a taken byte
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(in_valid));
endmodule

// File: tb/vdisp_decoder_tb.sv
module vdisp_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        in_start = 1'b0;
  logic        out_done;
  logic [31:0] out_value;
  logic [2:0]  out_len;
  logic        out_err;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vdisp_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_start(in_start), .out_done(out_done),
    .out_value(out_value), .out_len(out_len), .out_err(out_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbytes(input logic [7:0] b0);
    return !b0[7] ? 1 : (b0[6] ? 4 : 2);
  endfunction

  function automatic longint expv(input logic [31:0] bw, input int n);
    longint v;
    if (n == 1) begin
      v = longint'(bw[30:24]);
      if (bw[30]) v = v - 128;
    end else if (n == 2) begin
      v = longint'(bw[29:16]);
      if (bw[29]) v = v - 16384;
    end else begin
      v = longint'(bw[29:0]);
      if (bw[29]) v = v - (longint'(1) << 30);
    end
    return v;
  endfunction

  // Sends one displacement (bytes packed most significant first in bw);
  // entered and left on a falling edge.
  task automatic run(input logic [31:0] bw, input int gap, input string req);
    int n;
    longint e;
    n = nbytes(bw[31:24]);
    e = expv(bw, n);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < ((i > 0) ? gap : 0); g++) begin
        in_valid = 1'b0; in_start = 1'b1; in_byte = 8'hFF;
        @(negedge clk);
        chk(!out_done, "R8 gap no done", longint'(out_done), 0);
      end
      in_valid = 1'b1; in_start = (i == 0); in_byte = bw[31-8*i -: 8];
      @(negedge clk);
      if (i < n-1) chk(!out_done, "R5 no early done", longint'(out_done), 0);
    end
    in_valid = 1'b0; in_start = 1'b0;
    chk(out_done == 1'b1, {req, " done"}, longint'(out_done), 1);
    chk(out_len == 3'(n), {req, " len"}, longint'(out_len), longint'(n));
    chk(longint'($signed(out_value)) == e, {req, " value"}, longint'($signed(out_value)), e);
    chk(!out_err, {req, " no err"}, longint'(out_err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R5 watchdog: act=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_done, "R9 reset done", longint'(out_done), 0);
    chk(!out_err, "R9 reset err", longint'(out_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", longint'(in_ready), 1);
    chk(!out_done, "R9 idle done", longint'(out_done), 0);

    // R2: every one-byte displacement, back to back
    for (int b = 0; b < 128; b++) run({8'(b), 24'h0}, 0, "R2");

    // R3: every two-byte prefix with edge-case second bytes
    for (int b = 128; b < 192; b++) begin
      run({8'(b), 8'h00, 16'h0}, 0, "R3");
      run({8'(b), 8'h7F, 16'h0}, 1, "R3");
      run({8'(b), 8'h80, 16'h0}, 0, "R3");
      run({8'(b), 8'hFF, 16'h0}, 2, "R3");
    end

    // R4: every four-byte prefix with varied tails and gaps (R8)
    for (int b = 192; b < 256; b++) begin
      run({8'(b), 24'h000000}, b % 3, "R4");
      run({8'(b), 24'hFFFFFF}, 0, "R4");
      run({8'(b), 24'h5A3C81}, (b % 4) + 1, "R4 R8");
    end
    chk(in_ready == 1'b1, "R1 ready after traffic", longint'(in_ready), 1);

    // R6: bytes without start while idle are ignored
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1; in_start = 1'b0; in_byte = 8'(8'hC0 + k);
      @(negedge clk);
      chk(!out_done, "R6 ignored done", longint'(out_done), 0);
      chk(!out_err, "R6 ignored err", longint'(out_err), 0);
    end
    run({8'hBF, 8'hFE, 16'h0}, 0, "R6 after ignored");

    // R7: abort into a one-byte displacement
    in_valid = 1'b1; in_start = 1'b1; in_byte = 8'hC1;
    @(negedge clk);
    in_start = 1'b0; in_byte = 8'h22;
    @(negedge clk);
    in_start = 1'b1; in_byte = 8'h3F;
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
    chk(out_err == 1'b1, "R7 err", longint'(out_err), 1);
    chk(out_done == 1'b1, "R7 done with err", longint'(out_done), 1);
    chk(out_len == 3'd1, "R7 len", longint'(out_len), 1);
    chk(longint'($signed(out_value)) == 63, "R7 value", longint'($signed(out_value)), 63);
    @(negedge clk);
    chk(!out_err, "R7 err one cycle", longint'(out_err), 0);
    chk(!out_done, "R5 done one cycle", longint'(out_done), 0);

    // R7: abort into a two-byte displacement
    in_valid = 1'b1; in_start = 1'b1; in_byte = 8'h80;
    @(negedge clk);
    in_start = 1'b1; in_byte = 8'hA0;
    @(negedge clk);
    chk(out_err == 1'b1, "R7 err restart", longint'(out_err), 1);
    chk(!out_done, "R7 no done yet", longint'(out_done), 0);
    in_start = 1'b0; in_byte = 8'h01;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_err, "R7 err cleared", longint'(out_err), 0);
    chk(out_done == 1'b1, "R7 restart done", longint'(out_done), 1);
    chk(out_len == 3'd2, "R7 restart len", longint'(out_len), 2);
    chk(longint'($signed(out_value)) == -8191, "R7 restart value",
        longint'($signed(out_value)), -8191);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule